// File: doc/BRIEF.md
# PCIe Endpoint Interrupt Request Controller

This block sits between the application logic of a PCIe endpoint and its transaction layer. It turns application interrupt requests into link traffic. It keeps private shadow copies of the Command register and of the message-signalled interrupt capability. Those copies are loaded through a plain configuration-write port. From them it picks exactly one interrupt mode: legacy level-sensitive INTx, MSI, or MSI-X.

In MSI mode, the application raises `msi_req` together with a traffic class and a vector number. The block then emits one posted memory write as a stream of 32-bit words. First come three or four header words, then a single payload word. Once the last word has been taken downstream, the block returns a one-cycle `msi_ack`.

The TLP output is valid/ready. A word is transferred on a rising edge where `tlp_valid` and `tlp_ready` are both high. While `tlp_valid` is high and `tlp_ready` is low, the block holds `tlp_data`, `tlp_sop` and `tlp_eop` unchanged. The block never withdraws `tlp_valid` before the word is taken. Back-pressure may last any number of cycles.

In legacy mode, the block passes the application's level request to a registered INTx output. MSI-X vector tables are kept elsewhere. When MSI-X mode is selected, this block emits nothing.

Top module: `pcie_irq_ctrl`

## Requirements
- R1: After reset `irq_mode` is 0 (legacy), and `intx_asserted`, `tlp_valid` and `msi_ack` are low.
- R2: A configuration write to byte offset 0x050 loads the MSI control dword. Bit 16 of that dword is the MSI enable, and bits 22:20 are the enabled-vector field (MME). With MSI enabled and MSI-X off, `irq_mode` reads 1.
- R3: When parameter `MSIX_EN` is 1, bit 31 of the dword at offset 0x068 enables MSI-X. MSI-X overrides MSI and gives `irq_mode` = 2. When `MSIX_EN` is 0, that bit has no effect. `irq_mode` never reads 3.
- R4: Offset 0x004 is the Command register. Bit 2 of it is bus-master enable and bit 10 is Interrupt Disable. `intx_asserted` equals, one cycle later, `intx_level` AND legacy mode AND NOT Interrupt Disable.
- R5: In MSI mode with bus-master enable clear, a held request produces no TLP word and no acknowledge.
- R6: When the upper address (offset 0x058) is zero, the write uses a 3-word header. Word 0 is 0x40000001 | tc<<20. Word 1 is {requester_id, 8'h00, 8'h0F}. Word 2 is the low address (offset 0x054) with bits 1:0 cleared. When the upper address is non-zero, the header has 4 words: word 0 is 0x60000001 | tc<<20, word 1 is as before, word 2 is the upper address and word 3 is the low address.
- R7: The single payload word is the 16-bit message data (offset 0x05C, bits 15:0), zero-extended. Its low min(MME,5) bits are replaced by the same bits of `msi_vec`, and higher vector bits are dropped.
- R8: While `tlp_valid` is high and `tlp_ready` is low, all stream outputs stay stable. `tlp_sop` marks the first word and `tlp_eop` the payload word.
- R9: `msi_ack` is high for exactly one cycle. It comes in the cycle right after the payload word is accepted.
- R10: A TLP starts only in MSI mode, and `intx_asserted` is low in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address of the written dword |
| cfg_wdata | input | 32 | Configuration write data |
| requester_id | input | 16 | Bus/device/function identity placed in the header |
| msi_req | input | 1 | MSI request, held until acknowledged |
| msi_tc | input | 3 | Traffic class for the MSI write |
| msi_vec | input | 5 | Vector number merged into the payload |
| msi_ack | output | 1 | One-cycle acknowledge of a finished MSI |
| intx_level | input | 1 | Application legacy interrupt level |
| intx_asserted | output | 1 | Registered INTx assert (1) / deassert (0) state |
| irq_mode | output | 2 | 0 legacy, 1 MSI, 2 MSI-X |
| tlp_data | output | 32 | TLP word |
| tlp_sop | output | 1 | First word of TLP |
| tlp_eop | output | 1 | Last word of TLP |
| tlp_valid | output | 1 | Word valid |
| tlp_ready | input | 1 | Downstream accepts word |

## Verification
The MSI path is driven with a zero upper address and with a non-zero one. The first case exercises the 3-word header and the second the 4-word header, so a wrong format code or a missing address word is caught. One frame is sent with `tlp_ready` always high and another with `tlp_ready` toggling. The toggling run separates correct holding under back-pressure from words that are skipped or changed early. Payload merging is tried with a small MME and with an MME above the limit, which exposes a wrong mask width or a missing clamp. Requests are also made with bus mastering off and in MSI-X mode; both must stay silent. A second instance built without MSI-X shows that its enable bit is ignored.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_MSI    = 2'd1,
    MODE_MSIX   = 2'd2
  } mode_e;

  // configuration byte offsets and bit positions the block decodes
  localparam logic [11:0] OFS_COMMAND  = 12'h004;
  localparam logic [11:0] OFS_MSI_CTL  = 12'h050;
  localparam logic [11:0] OFS_MSI_ALO  = 12'h054;
  localparam logic [11:0] OFS_MSI_AHI  = 12'h058;
  localparam logic [11:0] OFS_MSI_DATA = 12'h05C;
  localparam logic [11:0] OFS_MSIX_CTL = 12'h068;

  localparam int BIT_BUS_MASTER = 2;
  localparam int BIT_INT_DIS    = 10;
  localparam int BIT_MSI_ON     = 16;
  localparam int BIT_MME_LO     = 20;
  localparam int BIT_MSIX_ON    = 31;

  localparam logic [2:0] FMT_3DW_DATA = 3'b010;
  localparam logic [2:0] FMT_4DW_DATA = 3'b011;
  localparam logic [4:0] TYPE_MEM     = 5'b00000;

endpackage

// File: rtl/irq_cfg_shadow.sv
module irq_cfg_shadow
  import irq_pkg::*;
#(
  parameter bit MSIX_EN = 1'b1,
  parameter int MSG_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [11:0]      cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic             bus_master,
  output logic             int_disable,
  output logic [2:0]       mme,
  output logic [31:0]      addr_lo,
  output logic [31:0]      addr_hi,
  output logic [MSG_W-1:0] msg_data,
  output mode_e            mode
);

  logic [11:0] dw_addr;
  logic        msi_on;
  logic        msix_on;
  logic        unused_bits;

  assign dw_addr     = {cfg_addr[11:2], 2'b00};
  assign unused_bits = ^{cfg_addr[1:0], cfg_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_master  <= 1'b0;
      int_disable <= 1'b0;
      msi_on      <= 1'b0;
      mme         <= '0;
      addr_lo     <= '0;
      addr_hi     <= '0;
      msg_data    <= '0;
    end else if (cfg_we) begin
      unique case (dw_addr)
        OFS_COMMAND: begin
          bus_master  <= cfg_wdata[BIT_BUS_MASTER];
          int_disable <= cfg_wdata[BIT_INT_DIS];
        end
        OFS_MSI_CTL: begin
          msi_on <= cfg_wdata[BIT_MSI_ON];
          mme    <= cfg_wdata[BIT_MME_LO +: 3];
        end
        OFS_MSI_ALO:  addr_lo  <= {cfg_wdata[31:2], 2'b00};
        OFS_MSI_AHI:  addr_hi  <= cfg_wdata;
        OFS_MSI_DATA: msg_data <= cfg_wdata[MSG_W-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (MSIX_EN) begin : g_msix
      logic msix_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                msix_q <= 1'b0;
        else if (cfg_we && dw_addr == OFS_MSIX_CTL) msix_q <= cfg_wdata[BIT_MSIX_ON];
      end
      assign msix_on = msix_q;
    end else begin : g_no_msix
      assign msix_on = 1'b0;
    end
  endgenerate

  // exactly one mode at a time; MSI-X has precedence over MSI
  always_comb begin
    mode = MODE_LEGACY;
    if (msix_on)     mode = MODE_MSIX;
    else if (msi_on) mode = MODE_MSI;
  end

endmodule

// File: rtl/irq_intx_drv.sv
module irq_intx_drv
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  int_disable,
  input  logic  level,
  output logic  intx_asserted
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intx_asserted <= 1'b0;
    else        intx_asserted <= level && (mode == MODE_LEGACY) && !int_disable;
  end

endmodule

// File: rtl/irq_msi_tx.sv
module irq_msi_tx
  import irq_pkg::*;
#(
  parameter int NUM_W   = 5,
  parameter int MSG_W   = 16,
  parameter int MME_MAX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             bus_master,
  input  logic [31:0]      addr_lo,
  input  logic [31:0]      addr_hi,
  input  logic [MSG_W-1:0] msg_data,
  input  logic [2:0]       mme,
  input  logic [15:0]      requester_id,
  input  logic             req,
  input  logic [2:0]       tc,
  input  logic [NUM_W-1:0] vec,
  output logic             ack,
  output logic [31:0]      tlp_data,
  output logic             tlp_valid,
  output logic             tlp_sop,
  output logic             tlp_eop,
  input  logic             tlp_ready
);

  localparam int WORDS_MAX = 5;
  localparam int IDX_W     = $clog2(WORDS_MAX);
  localparam int SLOTS     = 1 << IDX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_ACK} state_e;

  state_e           state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [31:0]      wbuf [SLOTS];
  logic [31:0]      cand [SLOTS];
  logic             start;
  logic             four_dw;
  logic [31:0]      dw0;
  logic [31:0]      dw1;
  logic [MSG_W-1:0] vmask;
  logic [MSG_W-1:0] merged;
  logic [31:0]      payload;
  int               eff_bits;

  assign start   = (state == ST_IDLE) && req && (mode == MODE_MSI) && bus_master;
  assign four_dw = (addr_hi != '0);

  // vector-field width from MME, clamped to the largest legal count
  always_comb begin
    eff_bits = (int'(mme) > MME_MAX) ? MME_MAX : int'(mme);
    for (int b = 0; b < MSG_W; b++) vmask[b] = (b < eff_bits);
    merged  = (msg_data & ~vmask) | (MSG_W'(vec) & vmask);
    payload = {{(32-MSG_W){1'b0}}, merged};
  end

  assign dw0 = {(four_dw ? FMT_4DW_DATA : FMT_3DW_DATA), TYPE_MEM, 1'b0, tc,
                10'd0, 10'd1};
  assign dw1 = {requester_id, 8'h00, 4'h0, 4'hF};

  always_comb begin
    for (int i = 0; i < SLOTS; i++) cand[i] = '0;
    cand[0] = dw0;
    cand[1] = dw1;
    if (four_dw) begin
      cand[2] = addr_hi;
      cand[3] = addr_lo;
      cand[4] = payload;
    end else begin
      cand[2] = addr_lo;
      cand[3] = payload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      last_idx <= '0;
      for (int i = 0; i < SLOTS; i++) wbuf[i] <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          for (int i = 0; i < SLOTS; i++) wbuf[i] <= cand[i];
          last_idx <= four_dw ? IDX_W'(4) : IDX_W'(3);
          idx      <= '0;
          state    <= ST_SEND;
        end
        ST_SEND: if (tlp_ready) begin
          if (idx == last_idx) state <= ST_ACK;
          else                 idx   <= idx + 1'b1;
        end
        ST_ACK:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tlp_valid = (state == ST_SEND);
  assign tlp_data  = wbuf[idx];
  assign tlp_sop   = tlp_valid && (idx == '0);
  assign tlp_eop   = tlp_valid && (idx == last_idx);
  assign ack       = (state == ST_ACK);

endmodule

// File: rtl/pcie_irq_ctrl.sv
module pcie_irq_ctrl
  import irq_pkg::*;
#(
  parameter bit MSIX_EN = 1'b1,
  parameter int NUM_W   = 5,
  parameter int MSG_W   = 16,
  parameter int MME_MAX = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [15:0] requester_id,
  input  logic        msi_req,
  input  logic [2:0]  msi_tc,
  input  logic [4:0]  msi_vec,
  output logic        msi_ack,
  input  logic        intx_level,
  output logic        intx_asserted,
  output logic [1:0]  irq_mode,
  output logic [31:0] tlp_data,
  output logic        tlp_sop,
  output logic        tlp_eop,
  output logic        tlp_valid,
  input  logic        tlp_ready
);

  mode_e            mode;
  logic             bus_master;
  logic             int_disable;
  logic [2:0]       mme;
  logic [31:0]      addr_lo;
  logic [31:0]      addr_hi;
  logic [MSG_W-1:0] msg_data;

  irq_cfg_shadow #(.MSIX_EN(MSIX_EN), .MSG_W(MSG_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_master(bus_master), .int_disable(int_disable),
    .mme(mme), .addr_lo(addr_lo), .addr_hi(addr_hi), .msg_data(msg_data),
    .mode(mode)
  );

  irq_intx_drv u_intx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .int_disable(int_disable),
    .level(intx_level), .intx_asserted(intx_asserted)
  );

  irq_msi_tx #(.NUM_W(NUM_W), .MSG_W(MSG_W), .MME_MAX(MME_MAX)) u_msi (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bus_master(bus_master),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .msg_data(msg_data), .mme(mme),
    .requester_id(requester_id), .req(msi_req), .tc(msi_tc),
    .vec(NUM_W'(msi_vec)), .ack(msi_ack), .tlp_data(tlp_data),
    .tlp_valid(tlp_valid), .tlp_sop(tlp_sop), .tlp_eop(tlp_eop),
    .tlp_ready(tlp_ready)
  );

  assign irq_mode = mode;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  irq_mode,
  input logic        intx_asserted,
  input logic        msi_req,
  input logic        msi_ack,
  input logic [31:0] tlp_data,
  input logic        tlp_sop,
  input logic        tlp_eop,
  input logic        tlp_valid,
  input logic        tlp_ready
);

  a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mode != 2'd3);

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tlp_valid && !tlp_ready) |=> (tlp_valid && $stable(tlp_data) &&
                                   $stable(tlp_sop) && $stable(tlp_eop)));

  a_r8_sop_not_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (tlp_valid && tlp_sop) |-> !tlp_eop);

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    msi_ack |=> !msi_ack);

  a_r9_ack_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_ack) |-> $past(tlp_valid && tlp_ready && tlp_eop));

  a_r9_ack_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
    msi_ack |-> (!tlp_valid && $past(msi_req)));

  a_r10_start_in_msi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tlp_valid) |-> ($past(irq_mode) == 2'd1 && tlp_sop));

  a_r10_intx_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    intx_asserted |-> ($past(irq_mode) == 2'd0));

endmodule

bind pcie_irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode), .intx_asserted(intx_asserted),
  .msi_req(msi_req), .msi_ack(msi_ack), .tlp_data(tlp_data), .tlp_sop(tlp_sop),
  .tlp_eop(tlp_eop), .tlp_valid(tlp_valid), .tlp_ready(tlp_ready)
);

// File: tb/test_pcie_irq_ctrl.sv
module test_pcie_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] requester_id = 16'h3A05;
  logic        msi_req = 1'b0;
  logic [2:0]  msi_tc = '0;
  logic [4:0]  msi_vec = '0;
  logic        intx_level = 1'b0;
  logic        tlp_ready = 1'b0;
  logic        msi_ack, intx_asserted, tlp_sop, tlp_eop, tlp_valid;
  logic [1:0]  irq_mode;
  logic [31:0] tlp_data;
  logic        n_ack, n_intx, n_sop, n_eop, n_valid;
  logic [1:0]  n_mode;
  logic [31:0] n_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench copy of programmed values
  logic [31:0] b_alo = '0, b_ahi = '0;
  logic [15:0] b_data = '0;
  logic [2:0]  b_mme = '0;

  always #2.5 clk = ~clk;

  pcie_irq_ctrl i_pcie_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .requester_id(requester_id), .msi_req(msi_req),
    .msi_tc(msi_tc), .msi_vec(msi_vec), .msi_ack(msi_ack),
    .intx_level(intx_level), .intx_asserted(intx_asserted), .irq_mode(irq_mode),
    .tlp_data(tlp_data), .tlp_sop(tlp_sop), .tlp_eop(tlp_eop),
    .tlp_valid(tlp_valid), .tlp_ready(tlp_ready)
  );

  pcie_irq_ctrl #(.MSIX_EN(1'b0)) i_no_msix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .requester_id(requester_id), .msi_req(1'b0),
    .msi_tc(msi_tc), .msi_vec(msi_vec), .msi_ack(n_ack),
    .intx_level(intx_level), .intx_asserted(n_intx), .irq_mode(n_mode),
    .tlp_data(n_data), .tlp_sop(n_sop), .tlp_eop(n_eop),
    .tlp_valid(n_valid), .tlp_ready(1'b1)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] exp_payload(input logic [4:0] v);
    int n;
    logic [15:0] m;
    n = (b_mme > 3'd5) ? 5 : int'(b_mme);
    m = 16'((32'd1 << n) - 1);
    return {16'h0, (b_data & ~m) | ({11'h0, v} & m)};
  endfunction

  function automatic logic [31:0] exp_word(input int i, input logic [2:0] tc,
                                           input logic [4:0] v);
    bit four = (b_ahi != 0);
    if (i == 0) return (four ? 32'h6000_0001 : 32'h4000_0001) | (32'(tc) << 20);
    if (i == 1) return {requester_id, 16'h000F};
    if (four) begin
      if (i == 2) return b_ahi;
      if (i == 3) return {b_alo[31:2], 2'b00};
      return exp_payload(v);
    end
    if (i == 2) return {b_alo[31:2], 2'b00};
    return exp_payload(v);
  endfunction

  // send one MSI and compare every word; stall toggles tlp_ready
  task automatic run_msi(input logic [2:0] tc, input logic [4:0] v, input bit stall);
    logic [31:0] got [8];
    int n = 0, cyc = 0, acc_cyc = -10;
    bit prev_stall = 0;
    logic [31:0] prev_d = '0;
    int nexp = (b_ahi != 0) ? 5 : 4;
    @(negedge clk);
    msi_tc = tc; msi_vec = v; msi_req = 1'b1;
    while (!msi_ack && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (msi_ack) break;
      if (prev_stall)
        chk(tlp_valid && tlp_data == prev_d, "R8 hold under stall", tlp_data, prev_d);
      tlp_ready = stall ? cyc[0] : 1'b1;
      if (tlp_valid && tlp_ready && n < 8) begin
        got[n] = tlp_data;
        chk(tlp_sop == (n == 0), "R8 sop position", 32'(tlp_sop), 32'(n == 0));
        chk(tlp_eop == (n == nexp - 1), "R8 eop position", 32'(tlp_eop), 32'(n == nexp - 1));
        if (tlp_eop) acc_cyc = cyc;
        n++;
      end
      prev_stall = tlp_valid && !tlp_ready;
      prev_d = tlp_data;
    end
    chk(msi_ack == 1'b1, "R9 ack seen", 32'(msi_ack), 1);
    chk(cyc == acc_cyc + 1, "R9 ack one cycle after last word", cyc, acc_cyc + 1);
    msi_req = 1'b0; tlp_ready = 1'b0;
    chk(n == nexp, "R6 word count", n, nexp);
    for (int i = 0; i < n && i < nexp; i++)
      chk(got[i] == exp_word(i, tc, v), (i == nexp - 1) ? "R7 payload" : "R6 header",
          got[i], exp_word(i, tc, v));
    @(negedge clk);
    chk(!msi_ack && !tlp_valid, "R9 ack single cycle", 32'(msi_ack), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(irq_mode == 2'd0, "R1 mode after reset", irq_mode, 0);
    chk(!intx_asserted && !tlp_valid && !msi_ack, "R1 outputs idle",
        {intx_asserted, tlp_valid, msi_ack}, 0);
  endtask

  task automatic t_intx();
    intx_level = 1'b1;
    @(negedge clk);
    chk(intx_asserted == 1'b1, "R4 intx follows level", intx_asserted, 1);
    cfg_write(12'h004, 32'h0000_0400);
    @(negedge clk);
    chk(intx_asserted == 1'b0, "R4 interrupt disable masks", intx_asserted, 0);
    cfg_write(12'h004, 32'h0000_0000);
    @(negedge clk);
    chk(intx_asserted == 1'b1, "R4 re-assert after enable", intx_asserted, 1);
    intx_level = 1'b0;
    @(negedge clk);
    chk(intx_asserted == 1'b0, "R4 deassert with level", intx_asserted, 0);
    intx_level = 1'b1;
  endtask

  task automatic t_msi_enable();
    b_mme = 3'd2;
    cfg_write(12'h050, 32'h0021_0000);
    chk(irq_mode == 2'd1, "R2 MSI mode", irq_mode, 1);
    @(negedge clk);
    chk(intx_asserted == 1'b0, "R10 intx low in MSI", intx_asserted, 1'b0);
  endtask

  task automatic t_no_bus_master();
    @(negedge clk);
    msi_tc = 3'd1; msi_vec = 5'd3; msi_req = 1'b1; tlp_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (tlp_valid || msi_ack) break;
    end
    chk(!tlp_valid && !msi_ack, "R5 held without bus master", {tlp_valid, msi_ack}, 0);
    msi_req = 1'b0; tlp_ready = 1'b0;
  endtask

  task automatic t_msi_3dw();
    b_alo = 32'hFEE0_100F; b_data = 16'h1230; b_ahi = 0;
    cfg_write(12'h004, 32'h0000_0004);
    cfg_write(12'h054, b_alo);
    cfg_write(12'h058, b_ahi);
    cfg_write(12'h05C, {16'h0, b_data});
    run_msi(3'd5, 5'h17, 1'b0);
  endtask

  task automatic t_msi_4dw_stall();
    b_ahi = 32'h0000_0012;
    cfg_write(12'h058, b_ahi);
    run_msi(3'd2, 5'h0A, 1'b1);
  endtask

  task automatic t_mme_clamp();
    b_mme = 3'd7; b_data = 16'h4321;
    cfg_write(12'h050, 32'h0071_0000);
    cfg_write(12'h05C, {16'hFFFF, b_data});
    run_msi(3'd0, 5'h1F, 1'b0);
  endtask

  task automatic t_msix();
    cfg_write(12'h068, 32'h8000_0000);
    chk(irq_mode == 2'd2, "R3 MSI-X overrides", irq_mode, 2);
    chk(n_mode == 2'd1, "R3 MSI-X ignored when not built", n_mode, 1);
    msi_req = 1'b1; tlp_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (tlp_valid || msi_ack) break;
    end
    chk(!tlp_valid && !msi_ack, "R10 no MSI frame in MSI-X", {tlp_valid, msi_ack}, 0);
    chk(!intx_asserted, "R10 intx low in MSI-X", intx_asserted, 0);
    msi_req = 1'b0; tlp_ready = 1'b0;
    cfg_write(12'h068, 32'h0);
    cfg_write(12'h050, 32'h0);
    chk(irq_mode == 2'd0 && n_mode == 2'd0, "R1 back to legacy", irq_mode, 0);
    @(negedge clk);
    chk(intx_asserted == 1'b1, "R4 intx resumes in legacy", intx_asserted, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_intx();
    t_msi_enable();
    t_no_bus_master();
    t_msi_3dw();
    t_msi_4dw_stall();
    t_mme_clamp();
    t_msix();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule